// File: doc/BRIEF.md
# NAND Raw Page Layout Router

This block walks the byte stream of one raw physical NAND page and says, for every byte, where that byte belongs logically. A page on the flash is laid out as a short metadata header, then data packets, each followed by its own ECC bytes, with a six-byte bad-block-marker area wedged into the last packet. Software and the ECC engine see instead a flat data buffer and a spare buffer that begins with the marker and metadata and continues with all ECC bytes back to back. The router turns each physical position into a tag (data, spare or marker) and an index into the buffer the tag names.

In the read direction the block takes flash bytes on a valid/ready input and delivers each one, one cycle later, on a valid/ready output together with its tag and index, ready to be written into a buffer. In the write direction it needs no input: it produces the same tag and index sequence in physical order, so that a buffer read port can gather the bytes for the flash. A skip option drops all data-buffer positions, for reads and writes that touch only the spare area. The layout is set by four parameters: page data size, packet size, step count and ECC strength. The page size must equal step count times packet size, and the bytes left before the marker area when the last packet begins must be between one and one packet.

Top module: `nand_layout_router`

## Requirements
- R1: A transfer covers 4 + STEPS×(PKT_BYTES + E) + 6 physical positions, where E = ceil(STRENGTH×15/8) ECC bytes per step (298 positions with the defaults, E = 8); out_last is 1 on the final beat only, and no beat follows it until a new start.
- R2: The first 4 physical positions are tagged spare (out_tag = 1) with indexes 6, 7, 8, 9 in order.
- R3: Every data position is tagged data (out_tag = 0), and the data indexes run 0 to PAGE_BYTES−1 without gaps in physical order.
- R4: ECC byte j of step i is tagged spare with index 10 + i×E + j; no spare beat carries an index outside 6 to 9 + STEPS×E.
- R5: The positions PAGE_BYTES to PAGE_BYTES+5 are tagged marker (out_tag = 2) with indexes 0 to 5; the last packet's data runs up to just before them and resumes right after them, and that packet's ECC comes last.
- R6: In the read direction each accepted input byte appears on out_data, unchanged, with out_valid high after exactly one clock edge.
- R7: While out_valid is high and out_ready is low, out_valid, out_tag, out_idx and out_data hold their values.
- R8: A start with start_write = 1 selects the write direction: in_ready stays 0, the beats follow the same tag and index order as a read, and out_data is 0.
- R9: A start with start_skip = 1 yields no data-tagged beat; in the read direction the data bytes are still accepted, so the spare and marker beats keep their positions.
- R10: A start pulse while a transfer runs, or while its final beat is still waiting on the output, is ignored.
- R11: After reset out_valid and in_ready are 0 until a start is given.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start | input | 1 | Begin a page transfer (one-cycle pulse) |
| start_write | input | 1 | Direction for the transfer being started: 1 write, 0 read |
| start_skip | input | 1 | Drop data-buffer positions for the transfer being started |
| in_valid | input | 1 | Flash byte available (read direction) |
| in_ready | output | 1 | Router takes the flash byte this cycle |
| in_data | input | 8 | Flash byte |
| out_valid | output | 1 | Routed beat available |
| out_ready | input | 1 | Consumer takes the beat this cycle |
| out_tag | output | 2 | 0 data, 1 spare, 2 marker |
| out_idx | output | IDX_W | Byte index inside the tagged buffer (the marker sits at spare bytes 0 to 5) |
| out_data | output | 8 | Routed byte in the read direction, 0 in the write direction |
| out_last | output | 1 | Final beat of the page |

## Verification
The critical overlap is the output register handing one beat to the consumer in the same cycle as it captures the next one from the flash side; if either half slips, a byte is lost or doubled, and around the marker area that shifts every later index. The bench provokes it by streaming a whole page with out_ready tied high and again with out_ready driven by a pseudo-random pattern, and judges each run by comparing every captured beat against a layout model computed from the requirements, plus a per-edge check that stalled beats hold still. A start pulse in the middle of a running page is the second overlap; it is judged by the page completing unchanged in its original direction and nothing following it.

// File: rtl/nlr_pkg.sv
package nlr_pkg;

    typedef enum logic [1:0] {
        TAG_DATA  = 2'd0,
        TAG_SPARE = 2'd1,
        TAG_MARK  = 2'd2
    } tag_e;

    typedef enum logic [2:0] {
        SEG_IDLE,
        SEG_META,
        SEG_PKT,
        SEG_ECC,
        SEG_HEAD,
        SEG_MARK,
        SEG_TAIL,
        SEG_ECCL
    } seg_e;

    localparam int META_BYTES = 4;
    localparam int MARK_BYTES = 6;
    localparam int META_SPARE_BASE = MARK_BYTES;
    localparam int ECC_SPARE_BASE  = MARK_BYTES + META_BYTES;
    localparam int FIELD_BITS = 15;

    function automatic int ecc_bytes_f(input int strength);
        return (strength * FIELD_BITS + 7) / 8;
    endfunction

    function automatic int max3_f(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/nlr_seg_walker.sv
module nlr_seg_walker
    import nlr_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    parameter int PKT_BYTES  = 64,
    parameter int STEPS      = 4,
    parameter int STRENGTH   = 4,
    parameter int IDX_W      = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             adv_i,
    output logic             active_o,
    output tag_e             tag_o,
    output logic [IDX_W-1:0] idx_o,
    output logic             data_o,
    output logic             last_o
);

    localparam int ECC_B   = ecc_bytes_f(STRENGTH);
    localparam int HEAD_B  = PAGE_BYTES - META_BYTES - (STEPS - 1) * (PKT_BYTES + ECC_B);
    localparam int TAIL_B  = PKT_BYTES - HEAD_B;
    localparam int MAX_SEG = max3_f(PKT_BYTES, ECC_B, MARK_BYTES);
    localparam int CNT_W   = $clog2(MAX_SEG + 1);
    localparam int STEP_W  = $clog2(STEPS + 1);

    typedef struct packed {
        seg_e              seg;
        logic [CNT_W-1:0]  cnt;
        logic [STEP_W-1:0] step;
        logic [IDX_W-1:0]  dptr;
        logic [IDX_W-1:0]  eptr;
    } walk_t;

    walk_t st_d, st_q;
    int    seg_len;
    logic  seg_end;
    logic  is_data;

    always_comb begin
        case (st_q.seg)
            SEG_META:           seg_len = META_BYTES;
            SEG_PKT:            seg_len = PKT_BYTES;
            SEG_ECC, SEG_ECCL:  seg_len = ECC_B;
            SEG_HEAD:           seg_len = HEAD_B;
            SEG_MARK:           seg_len = MARK_BYTES;
            SEG_TAIL:           seg_len = TAIL_B;
            default:            seg_len = 1;
        endcase
        seg_end = (int'(st_q.cnt) == seg_len - 1);
        is_data = (st_q.seg == SEG_PKT) || (st_q.seg == SEG_HEAD) || (st_q.seg == SEG_TAIL);
    end

    always_comb begin
        st_d = st_q;
        if (st_q.seg == SEG_IDLE) begin
            if (start_i) begin
                st_d.seg  = SEG_META;
                st_d.cnt  = '0;
                st_d.step = '0;
                st_d.dptr = '0;
                st_d.eptr = IDX_W'(ECC_SPARE_BASE);
            end
        end else if (adv_i) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
            if (is_data) begin
                st_d.dptr = st_q.dptr + IDX_W'(1);
            end
            if ((st_q.seg == SEG_ECC) || (st_q.seg == SEG_ECCL)) begin
                st_d.eptr = st_q.eptr + IDX_W'(1);
            end
            if (seg_end) begin
                st_d.cnt = '0;
                case (st_q.seg)
                    SEG_META: st_d.seg = (STEPS > 1) ? SEG_PKT : SEG_HEAD;
                    SEG_PKT:  st_d.seg = SEG_ECC;
                    SEG_ECC: begin
                        st_d.step = st_q.step + STEP_W'(1);
                        st_d.seg  = (int'(st_q.step) == STEPS - 2) ? SEG_HEAD : SEG_PKT;
                    end
                    SEG_HEAD: st_d.seg = SEG_MARK;
                    SEG_MARK: st_d.seg = (TAIL_B > 0) ? SEG_TAIL : SEG_ECCL;
                    SEG_TAIL: st_d.seg = SEG_ECCL;
                    default:  st_d.seg = SEG_IDLE;
                endcase
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{seg: SEG_IDLE, cnt: '0, step: '0, dptr: '0, eptr: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        case (st_q.seg)
            SEG_META: begin
                tag_o = TAG_SPARE;
                idx_o = IDX_W'(META_SPARE_BASE) + IDX_W'(st_q.cnt);
            end
            SEG_MARK: begin
                tag_o = TAG_MARK;
                idx_o = IDX_W'(st_q.cnt);
            end
            SEG_ECC, SEG_ECCL: begin
                tag_o = TAG_SPARE;
                idx_o = st_q.eptr;
            end
            default: begin
                tag_o = TAG_DATA;
                idx_o = st_q.dptr;
            end
        endcase
    end

    assign active_o = (st_q.seg != SEG_IDLE);
    assign data_o   = is_data;
    assign last_o   = (st_q.seg == SEG_ECCL) && seg_end;

endmodule

// File: rtl/nlr_beat_reg.sv
module nlr_beat_reg
    import nlr_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  tag_e             tag_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [7:0]       data_i,
    input  logic             last_i,
    input  logic             ready_i,
    output logic             can_load_o,
    output logic             valid_o,
    output tag_e             tag_o,
    output logic [IDX_W-1:0] idx_o,
    output logic [7:0]       data_o,
    output logic             last_o
);

    typedef struct packed {
        logic             valid;
        tag_e             tag;
        logic [IDX_W-1:0] idx;
        logic [7:0]       data;
        logic             last;
    } beat_t;

    beat_t bt_d, bt_q;

    always_comb begin
        bt_d = bt_q;
        if (load_i) begin
            bt_d.valid = 1'b1;
            bt_d.tag   = tag_i;
            bt_d.idx   = idx_i;
            bt_d.data  = data_i;
            bt_d.last  = last_i;
        end else if (ready_i) begin
            bt_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bt_q <= '{valid: 1'b0, tag: TAG_DATA, idx: '0, data: '0, last: 1'b0};
        end else begin
            bt_q <= bt_d;
        end
    end

    assign can_load_o = !bt_q.valid || ready_i;
    assign valid_o    = bt_q.valid;
    assign tag_o      = bt_q.tag;
    assign idx_o      = bt_q.idx;
    assign data_o     = bt_q.data;
    assign last_o     = bt_q.last;

endmodule

// File: rtl/nand_layout_router.sv
module nand_layout_router
    import nlr_pkg::*;
#(
    parameter int PAGE_BYTES = 256,
    parameter int PKT_BYTES  = 64,
    parameter int STEPS      = 4,
    parameter int STRENGTH   = 4,
    parameter int IDX_W      = $clog2((PAGE_BYTES > 10 + STEPS * ((STRENGTH * 15 + 7) / 8))
                                      ? PAGE_BYTES : 10 + STEPS * ((STRENGTH * 15 + 7) / 8))
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             start_write,
    input  logic             start_skip,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [7:0]       in_data,
    output logic             out_valid,
    input  logic             out_ready,
    output logic [1:0]       out_tag,
    output logic [IDX_W-1:0] out_idx,
    output logic [7:0]       out_data,
    output logic             out_last
);

    typedef struct packed {
        logic wr;
        logic skip;
    } mode_t;

    mode_t            mode_d, mode_q;
    logic             w_active;
    tag_e             w_tag;
    logic [IDX_W-1:0] w_idx;
    logic             w_data;
    logic             w_last;
    logic             start_ok;
    logic             drop;
    logic             adv;
    logic             load;
    logic             can_load;
    logic [7:0]       beat_data;
    tag_e             r_tag;
    logic             wr_mode;
    logic             skip_mode;

    // A new page may begin only once the walker is idle and the last beat has left.
    assign start_ok = start && !w_active && !out_valid;

    always_comb begin
        mode_d = mode_q;
        if (start_ok) begin
            mode_d.wr   = start_write;
            mode_d.skip = start_skip;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q <= '{wr: 1'b0, skip: 1'b0};
        end else begin
            mode_q <= mode_d;
        end
    end

    assign wr_mode   = mode_q.wr;
    assign skip_mode = mode_q.skip;

    always_comb begin
        drop = mode_q.skip && w_data;
        if (mode_q.wr) begin
            in_ready = 1'b0;
            adv      = w_active && (drop || can_load);
        end else begin
            in_ready = w_active && (drop || can_load);
            adv      = in_valid && in_ready;
        end
        load      = adv && !drop;
        beat_data = mode_q.wr ? 8'h00 : in_data;
    end

    nlr_seg_walker #(
        .PAGE_BYTES (PAGE_BYTES),
        .PKT_BYTES  (PKT_BYTES),
        .STEPS      (STEPS),
        .STRENGTH   (STRENGTH),
        .IDX_W      (IDX_W)
    ) u_walk (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_ok),
        .adv_i    (adv),
        .active_o (w_active),
        .tag_o    (w_tag),
        .idx_o    (w_idx),
        .data_o   (w_data),
        .last_o   (w_last)
    );

    nlr_beat_reg #(
        .IDX_W (IDX_W)
    ) u_beat (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .tag_i      (w_tag),
        .idx_i      (w_idx),
        .data_i     (beat_data),
        .last_i     (w_last),
        .ready_i    (out_ready),
        .can_load_o (can_load),
        .valid_o    (out_valid),
        .tag_o      (r_tag),
        .idx_o      (out_idx),
        .data_o     (out_data),
        .last_o     (out_last)
    );

    assign out_tag = r_tag;

endmodule

// File: rtl/nand_layout_router_chk.sv
module nand_layout_router_chk #(
    parameter int STEPS    = 4,
    parameter int STRENGTH = 4,
    parameter int IDX_W    = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             in_ready,
    input logic [7:0]       in_data,
    input logic             out_valid,
    input logic             out_ready,
    input logic [1:0]       out_tag,
    input logic [IDX_W-1:0] out_idx,
    input logic [7:0]       out_data,
    input logic             out_last,
    input logic             wr_mode,
    input logic             skip_mode
);

    localparam int SPARE_TOP = 10 + STEPS * ((STRENGTH * 15 + 7) / 8);

    a_r7_hold_stalled_beat: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_tag) && $stable(out_idx) && $stable(out_data));

    a_r6_read_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !wr_mode && !skip_mode |=> out_valid && (out_data == $past(in_data)));

    a_r1_nothing_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_ready && out_last |=> !out_valid);

    a_r5_marker_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_tag == 2'd2) |-> (int'(out_idx) < 6));

    a_r4_spare_range: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && (out_tag == 2'd1) |-> (int'(out_idx) >= 6) && (int'(out_idx) < SPARE_TOP));

    a_r8_write_zero_data: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && wr_mode |-> (out_data == 8'h00));

    a_r9_skip_no_data: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && skip_mode |-> (out_tag != 2'd0));

    a_r8_no_input_taken: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && wr_mode |-> !(in_valid && in_ready));

endmodule

bind nand_layout_router nand_layout_router_chk #(
    .STEPS    (STEPS),
    .STRENGTH (STRENGTH),
    .IDX_W    (IDX_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_data   (in_data),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_tag   (out_tag),
    .out_idx   (out_idx),
    .out_data  (out_data),
    .out_last  (out_last),
    .wr_mode   (wr_mode),
    .skip_mode (skip_mode)
);

// File: tb/nand_layout_router_test.sv
module nand_layout_router_test;

    localparam int PAGE  = 256;
    localparam int PKT   = 64;
    localparam int STEPS = 4;
    localparam int STR   = 4;
    localparam int ECC   = (STR * 15 + 7) / 8;
    localparam int HEAD  = PAGE - 4 - (STEPS - 1) * (PKT + ECC);
    localparam int TOTAL = 4 + STEPS * (PKT + ECC) + 6;
    localparam int IW    = 8;

    // position, expected tag, expected index
    localparam int NVEC = 17;
    localparam int VEC [NVEC][3] = '{
        '{0, 1, 6},     '{3, 1, 9},     '{4, 0, 0},     '{67, 0, 63},
        '{68, 1, 10},   '{75, 1, 17},   '{76, 0, 64},   '{147, 1, 25},
        '{219, 1, 33},  '{220, 0, 192}, '{255, 0, 227}, '{256, 2, 0},
        '{261, 2, 5},   '{262, 0, 228}, '{289, 0, 255}, '{290, 1, 34},
        '{297, 1, 41}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          start_write = 1'b0;
    logic          start_skip = 1'b0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [7:0]    in_data = 8'h00;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [1:0]    out_tag;
    logic [IW-1:0] out_idx;
    logic [7:0]    out_data;
    logic          out_last;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    int cap_tag  [0:511];
    int cap_idx  [0:511];
    int cap_data [0:511];
    int cap_last [0:511];
    int ncap = 0;
    bit seen_last = 0;
    bit lat_en = 0;
    bit bp_en = 0;
    bit wr_run = 0;
    int lat_bad = 0;
    int stall_bad = 0;
    int inrdy_bad = 0;
    bit prev_acc = 0;
    logic [7:0] prev_dat = 8'h00;
    bit prev_stall = 0;
    int ps_tag, ps_idx, ps_dat;
    logic [15:0] lfsr = 16'hACE1;

    nand_layout_router #(
        .PAGE_BYTES (PAGE),
        .PKT_BYTES  (PKT),
        .STEPS      (STEPS),
        .STRENGTH   (STR)
    ) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .start_write (start_write),
        .start_skip  (start_skip),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_data     (in_data),
        .out_valid   (out_valid),
        .out_ready   (out_ready),
        .out_tag     (out_tag),
        .out_idx     (out_idx),
        .out_data    (out_data),
        .out_last    (out_last)
    );

    always #10 clk = ~clk;

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog expired: actual=%0d cycles expected<150000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int pat(input int p);
        return (p * 7 + 3) & 255;
    endfunction

    // Layout model written from the requirements.
    function automatic void model(input int p, output int tag, output int idx);
        int q, k, r;
        if (p < 4) begin
            tag = 1; idx = 6 + p;
        end else begin
            q = p - 4;
            k = q / (PKT + ECC);
            if (k < STEPS - 1) begin
                r = q % (PKT + ECC);
                if (r < PKT) begin tag = 0; idx = k * PKT + r; end
                else begin tag = 1; idx = 10 + k * ECC + (r - PKT); end
            end else begin
                r = q - (STEPS - 1) * (PKT + ECC);
                if (r < HEAD) begin tag = 0; idx = (STEPS - 1) * PKT + r; end
                else if (r < HEAD + 6) begin tag = 2; idx = r - HEAD; end
                else if (r < PKT + 6) begin tag = 0; idx = (STEPS - 1) * PKT + r - 6; end
                else begin tag = 1; idx = 10 + (STEPS - 1) * ECC + (r - PKT - 6); end
            end
        end
    endfunction

    always @(posedge clk) begin
        #1;
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        out_ready = bp_en ? lfsr[0] : 1'b1;
    end

    // Monitor away from the active edge.
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall) begin
                if (!out_valid || out_tag != ps_tag || out_idx != ps_idx || out_data != ps_dat)
                    stall_bad++;
            end
            if (lat_en && prev_acc) begin
                if (!out_valid || out_data != prev_dat) lat_bad++;
            end
            if (wr_run && in_ready) inrdy_bad++;
            if (out_valid && out_ready) begin
                if (ncap < 512) begin
                    cap_tag[ncap]  = int'(out_tag);
                    cap_idx[ncap]  = int'(out_idx);
                    cap_data[ncap] = int'(out_data);
                    cap_last[ncap] = int'(out_last);
                end
                ncap++;
                if (out_last) seen_last = 1;
            end
            prev_stall = out_valid && !out_ready;
            ps_tag = int'(out_tag);
            ps_idx = int'(out_idx);
            ps_dat = int'(out_data);
            prev_acc = in_valid && in_ready;
            prev_dat = in_data;
        end
    end

    task automatic run(input bit wr, input bit skip, input bit bp, input int busy_pos);
        int pos;
        bit took;
        ncap = 0; seen_last = 0; lat_bad = 0; stall_bad = 0; inrdy_bad = 0;
        lat_en = !wr && !skip; bp_en = bp; wr_run = wr;
        @(posedge clk); #2;
        start = 1; start_write = wr; start_skip = skip;
        @(posedge clk); #2;
        start = 0; start_write = 0; start_skip = 0;
        if (!wr) begin
            pos = 0; in_valid = 1; in_data = 8'(pat(0));
            while (pos < TOTAL) begin
                @(negedge clk);
                took = in_valid && in_ready;
                @(posedge clk); #2;
                if (took) pos++;
                if (busy_pos >= 0 && pos == busy_pos) begin
                    start = 1; start_write = 1;
                end else begin
                    start = 0; start_write = 0;
                end
                in_data = 8'(pat(pos));
                in_valid = (pos < TOTAL);
            end
            start = 0; start_write = 0;
        end
        for (int w = 0; w < 3000 && !seen_last; w++) @(posedge clk);
        repeat (3) @(posedge clk);
        bp_en = 0; lat_en = 0; wr_run = 0;
        @(posedge clk); #2;
    endtask

    task automatic judge(input bit wr, input bit skip, input string req);
        int j, bad, lbad, t, i;
        j = 0; bad = 0; lbad = 0;
        for (int p = 0; p < TOTAL; p++) begin
            model(p, t, i);
            if (skip && t == 0) continue;
            if (j >= ncap || j >= 512) bad++;
            else begin
                if (cap_tag[j] != t || cap_idx[j] != i || cap_data[j] != (wr ? 0 : pat(p))) bad++;
                if (cap_last[j] != ((p == TOTAL - 1) ? 1 : 0)) lbad++;
            end
            j++;
        end
        chk(ncap == j, req, "beat count (R1)", ncap, j);
        chk(bad == 0, req, "beats differing from layout model", bad, 0);
        chk(lbad == 0, req, "out_last placement R1", lbad, 0);
    endtask

    initial begin
        int t, i, idle_bad;

        // R11: reset state
        in_valid = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(out_valid == 1'b0, "R11", "out_valid in reset", int'(out_valid), 0);
        rst_n = 1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R11", "out_valid after reset", int'(out_valid), 0);
        chk(in_ready == 1'b0, "R11", "in_ready before start", int'(in_ready), 0);
        in_valid = 0;

        // Read page, no backpressure: R2 R3 R4 R5 R6
        run(0, 0, 0, -1);
        judge(0, 0, "R3");
        chk(lat_bad == 0, "R6", "one-cycle latency misses", lat_bad, 0);
        for (int k = 0; k < NVEC; k++) begin
            checks++;
            if (cap_tag[VEC[k][0]] != VEC[k][1] || cap_idx[VEC[k][0]] != VEC[k][2]) begin
                errors++;
                $display("FAIL R2/R3/R4/R5 position %0d: actual tag=%0d idx=%0d expected tag=%0d idx=%0d",
                         VEC[k][0], cap_tag[VEC[k][0]], cap_idx[VEC[k][0]], VEC[k][1], VEC[k][2]);
            end
        end
        model(TOTAL - 1, t, i);
        chk(i == 41 && t == 1, "R4", "model final spare index", i, 41);

        // Read page with random backpressure: R7
        run(0, 0, 1, -1);
        judge(0, 0, "R7");
        chk(stall_bad == 0, "R7", "stalled beat changed", stall_bad, 0);
        chk(lat_bad == 0, "R6", "latency under backpressure", lat_bad, 0);

        // Write direction, with backpressure: R8
        run(1, 0, 1, -1);
        judge(1, 0, "R8");
        chk(inrdy_bad == 0, "R8", "in_ready high in write", inrdy_bad, 0);

        // Skip mode read and write: R9
        run(0, 1, 0, -1);
        judge(0, 1, "R9");
        run(1, 1, 1, -1);
        judge(1, 1, "R9");

        // Start pulse mid-page: R10
        run(0, 0, 1, 120);
        judge(0, 0, "R10");
        idle_bad = 0;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            if (out_valid || in_ready) idle_bad++;
        end
        chk(idle_bad == 0, "R10", "activity after ignored start", idle_bad, 0);

        summary();
        $finish;
    end

endmodule